// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an external asynchronous static RAM of 32K words by 8 bits. The host makes one single-word request at a time: a strobe, a write flag, an address and write data. The block accepts the request only while its ready output is high. It then plays out one read or write cycle on the memory's active-low select, write strobe and output-enable lines. Every interval in that cycle is a whole number of clocks, worked out at elaboration from nanosecond timing parameters and the clock period.

A write is timed by the memory's overlap rule. The write window is the time during which the chip select and the write strobe are both low. The address and data are measured against the rising edge of the write strobe, which ends the window. Output enable stays high for the whole write. The block's own data driver turns on only after a bus-release interval and stays on for one clock beyond the end of the write. A read holds select and output enable low. The returned byte is captured once both the address-to-data time and the output-enable-to-data time have run out, and it is handed to the host with a one-clock valid pulse. After a read, ready stays low for an extra turnaround so that the memory can release the bus. Between cycles the select line is high, which keeps the memory in standby.

The memory data bus is presented as three separate signals: an output value, an output enable and an input value. The pad-level tri-state is not part of this block.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, and whenever ready is high, the select, write-strobe and output-enable lines are all high, the data driver is off and the read-valid output is low.
- R2: A request is taken on a rising clock edge at which both strobe and ready are high. Ready then stays low for the whole cycle: the write length after a write, or the read length plus the turnaround after a read. It is high again in the cycle that follows.
- R3: A write holds select low for WL clocks, starting in the cycle after acceptance. The write strobe is low for the first WE clocks of that span. The memory address equals the accepted host address throughout. WE = max(pulse width, address-to-end, release + data setup) and WL = max(write cycle, WE + 1).
- R4: Output enable stays high during every write.
- R5: The data driver turns on REL clocks into a write and stays on through the clock in which the write strobe rises. The driven value is the accepted write data and is stable for at least the data-setup count before that rising edge.
- R6: A read holds select and output enable low for RL clocks, starting in the cycle after acceptance. During the read the write strobe stays high and the data driver stays off.
- R7: The read byte is sampled on the CAP-th rising edge after acceptance, where CAP = max(address-to-data, output-enable-to-data) and RL = max(read cycle, CAP). Read-valid is high for exactly the following clock, and the read data holds the sampled byte.
- R8: After a read, select stays high for TURN clocks (the output-enable-to-high-Z count) before the next request can be taken. The data driver is never on while the memory may still be driving the bus.
- R9: Each interval in clocks is the nanosecond value divided by the clock period and rounded up, so any nonzero interval lasts at least one clock.
- R10: A byte written at an address is returned by a later read of that address, for every address bit position and every data value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 15 | Word address |
| host_wdata | input | 8 | Write data |
| host_rdy | output | 1 | High when a request can be taken |
| host_rdata | output | 8 | Last byte read |
| host_rvalid | output | 1 | One-clock pulse when host_rdata is new |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_out | output | 8 | Value to drive on the data bus |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_in | input | 8 | Value read from the data bus |

## Verification
The bench memory model returns a poison byte until enough consecutive read-enabled cycles have passed at a stable address. A controller that samples one clock early therefore returns wrong data instead of passing by luck. The model also tracks the length of the write window, the address stability and the data setup at every rising edge of the write strobe, and it stores a marker byte when any of these is short. A design that drops the write-strobe pulse or the data setup then fails on read-back. The model flags contention whenever the driver is on while the memory's read output has not yet released. This catches a missing turnaround or a driver that turns on too early. Every cycle's pin waveform is compared clock by clock against counts derived from the nanosecond parameters. The address sweep walks every single-bit and single-zero pattern, and one address takes all 256 data values.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and elaboration-time helpers for the SRAM cycle controller.
// Assumes all timing inputs are non-negative nanosecond integers.
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_TURN  = 2'd3
    } seq_state_t;

    // Nanoseconds to clocks, rounded up; zero stays zero, nonzero gives >= 1.
    function automatic int unsigned ns_to_clk(input int unsigned t_ns, input int unsigned clk_ns);
        if (t_ns == 0) return 0;
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
// Cycle sequencer: holds the operation state and the clock counter within it.
// Assumes WR_LEN, RD_LEN >= 1 and all lengths fit in CNT_W bits.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned WR_LEN   = 14,
    parameter int unsigned RD_LEN   = 14,
    parameter int unsigned TURN_LEN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    output seq_state_t       state,
    output logic [CNT_W-1:0] cnt,
    output logic             rdy,
    output logic             accept
);

    localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_LEN - 1);
    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'((TURN_LEN == 0) ? 0 : TURN_LEN - 1);

    assign rdy    = (state == ST_IDLE);
    assign accept = rdy && req;

    // Advance the operation state and its clock counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (req) state <= wr ? ST_WRITE : ST_READ;
                end
                ST_WRITE: begin
                    if (cnt == WR_LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_READ: begin
                    if (cnt == RD_LAST) begin
                        state <= (TURN_LEN == 0) ? ST_IDLE : ST_TURN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == TURN_LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // R2: a taken request always leaves idle on the next edge
    p_leave_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !rdy);

endmodule

// File: rtl/sram_pin_ctrl.sv
// Memory pin generator: latches the accepted address and data and decodes the
// strobes and the driver enable from the sequencer state. Strobes are a pure
// decode of registers, so they change only just after a clock edge.
// Assumes REL_LEN <= WE_LEN < WR_LEN and WE_LEN >= 1.
module sram_pin_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 15,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned WE_LEN  = 12,
    parameter int unsigned REL_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  seq_state_t        state,
    input  logic [CNT_W-1:0]  cnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_dq_oe
);

    localparam logic [CNT_W-1:0] WE_END  = CNT_W'(WE_LEN);
    localparam logic [CNT_W-1:0] REL_BEG = CNT_W'(REL_LEN);

    // Hold the address and write data of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= host_addr;
            mem_dq_out <= host_wdata;
        end
    end

    // Decode the strobes and driver enable from state and counter.
    always_comb begin
        mem_ce_n  = !((state == ST_WRITE) || (state == ST_READ));
        mem_oe_n  = !(state == ST_READ);
        mem_we_n  = !((state == ST_WRITE) && (cnt < WE_END));
        mem_dq_oe = (state == ST_WRITE) && (cnt >= REL_BEG) && (cnt <= WE_END);
    end

    // R4: output enable is high whenever the write strobe is low
    p_oe_off_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R5: the driver is on only inside a selected cycle with output enable high
    p_drive_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

    // R3: the address does not move while select stays low
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: rtl/sram_rd_capture.sv
// Read capture: samples the memory data bus on the edge that closes the
// access window and raises a one-clock valid pulse.
// Assumes 1 <= CAP_AT <= read length used by the sequencer.
module sram_rd_capture
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned CAP_AT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    localparam logic [CNT_W-1:0] CAP_CNT = CNT_W'(CAP_AT - 1);

    logic take;
    assign take = (state == ST_READ) && (cnt == CAP_CNT);

    // Register the sampled byte and the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= take;
            if (take) rdata <= dq_in;
        end
    end

    // R7: valid lasts exactly one clock
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    // R7: read data does not change while no capture occurs
    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |=> (rvalid || $stable(rdata)));

endmodule

// File: rtl/sram_cycle_ctrl.sv
// Top of the asynchronous SRAM cycle controller. Converts nanosecond timing
// parameters to clock counts and wires the sequencer, pin generator and read
// capture. Assumes the host keeps its request fields stable while strobing.
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 15,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_NS    = 5,
    parameter int unsigned T_WC_NS   = 70,
    parameter int unsigned T_PWE_NS  = 50,
    parameter int unsigned T_AW_NS   = 60,
    parameter int unsigned T_SD_NS   = 30,
    parameter int unsigned T_RC_NS   = 70,
    parameter int unsigned T_AA_NS   = 70,
    parameter int unsigned T_DOE_NS  = 35,
    parameter int unsigned T_HZOE_NS = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_rdy,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned N_WC   = ns_to_clk(T_WC_NS, CLK_NS);
    localparam int unsigned N_PWE  = ns_to_clk(T_PWE_NS, CLK_NS);
    localparam int unsigned N_AW   = ns_to_clk(T_AW_NS, CLK_NS);
    localparam int unsigned N_SD   = ns_to_clk(T_SD_NS, CLK_NS);
    localparam int unsigned N_RC   = ns_to_clk(T_RC_NS, CLK_NS);
    localparam int unsigned N_AA   = ns_to_clk(T_AA_NS, CLK_NS);
    localparam int unsigned N_DOE  = ns_to_clk(T_DOE_NS, CLK_NS);
    localparam int unsigned N_HZ   = ns_to_clk(T_HZOE_NS, CLK_NS);
    localparam int unsigned WE_LEN = umax(umax(N_PWE, N_AW), umax(N_HZ + N_SD, 1));
    localparam int unsigned WR_LEN = umax(N_WC, WE_LEN + 1);
    localparam int unsigned CAP_AT = umax(umax(N_AA, N_DOE), 1);
    localparam int unsigned RD_LEN = umax(N_RC, CAP_AT);
    localparam int unsigned CNT_W  = $clog2(umax(umax(WR_LEN, RD_LEN), N_HZ) + 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             accept;

    sram_seq_fsm #(
        .CNT_W(CNT_W), .WR_LEN(WR_LEN), .RD_LEN(RD_LEN), .TURN_LEN(N_HZ)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .req(host_req), .wr(host_wr),
        .state(state), .cnt(cnt), .rdy(host_rdy), .accept(accept)
    );

    sram_pin_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .WE_LEN(WE_LEN), .REL_LEN(N_HZ)
    ) pins_i (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .state(state), .cnt(cnt),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
    );

    sram_rd_capture #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .CAP_AT(CAP_AT)
    ) cap_i (
        .clk(clk), .rst_n(rst_n), .state(state), .cnt(cnt),
        .dq_in(mem_dq_in), .rdata(host_rdata), .rvalid(host_rvalid)
    );

    // R1: standby pins whenever the block is ready
    p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdy |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    // R5: the driver is still on in the clock where the write strobe rises
    p_hold_past_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    // R6: a read never pulses the write strobe
    p_read_no_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

endmodule

// File: tb/sram_cycle_ctrl_tb.sv
// Bench: a timing-aware memory model plus per-clock pin comparison against
// counts derived from the nanosecond parameters.
module sram_cycle_ctrl_tb_top;

    localparam int CLK_NS = 5;

    function automatic int cdiv(input int t);
        return (t == 0) ? 0 : (t + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_PWE  = cdiv(50);
    localparam int E_AW   = cdiv(60);
    localparam int E_SD   = cdiv(30);
    localparam int E_HZ   = cdiv(25);
    localparam int E_WE   = mx(mx(E_PWE, E_AW), E_HZ + E_SD);
    localparam int E_WL   = mx(cdiv(70), E_WE + 1);
    localparam int E_CAP  = mx(cdiv(70), cdiv(35));
    localparam int E_RL   = mx(cdiv(70), E_CAP);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, wr = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        rdy, rvalid, ce_n, we_n, oe_n, dq_oe;
    logic [7:0]  rdata, dq_out, dq_in;
    logic [14:0] maddr;

    int tests = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sram_cycle_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(req), .host_wr(wr),
        .host_addr(addr), .host_wdata(wdata), .host_rdy(rdy),
        .host_rdata(rdata), .host_rvalid(rvalid),
        .mem_ce_n(ce_n), .mem_we_n(we_n), .mem_oe_n(oe_n),
        .mem_addr(maddr), .mem_dq_out(dq_out), .mem_dq_oe(dq_oe),
        .mem_dq_in(dq_in)
    );

    // ---------------- memory model ----------------
    logic [7:0]  mem_m [int];
    logic [7:0]  rd_word = 8'hEE;
    logic        rd_ok = 1'b0;
    int          rd_cnt = 0, hz_cnt = 100;
    int          we_cnt = 0, a_cnt = 0, sd_cnt = 0;
    bit          in_wr = 0;
    logic [14:0] last_a = '0;
    logic [7:0]  last_d = '0;

    assign dq_in = rd_ok ? rd_word : 8'hEE;

    task automatic chk(input bit ok, input string msg);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            // read side: data valid only after a full access window
            if (!ce_n && !oe_n && we_n) begin
                rd_cnt = (rd_cnt > 0 && maddr == last_a) ? rd_cnt + 1 : 1;
                hz_cnt = 0;
            end else begin
                rd_cnt = 0;
                if (hz_cnt < 100) hz_cnt++;
            end
            rd_ok   <= (rd_cnt >= mx(cdiv(70), cdiv(35)));
            rd_word <= mem_m.exists(int'(maddr)) ? mem_m[int'(maddr)] : 8'h00;
            // R8: driver must not overlap a memory that is still driving
            if (dq_oe && (rd_cnt > 0 || hz_cnt < E_HZ))
                chk(0, $sformatf("R8 bus contention hz_cnt=%0d expected >=%0d", hz_cnt, E_HZ));
            // write side: overlap of select and strobe
            if (!ce_n && !we_n) begin
                a_cnt  = (in_wr && maddr == last_a) ? a_cnt + 1 : 1;
                sd_cnt = dq_oe ? ((in_wr && dq_out == last_d && sd_cnt > 0) ? sd_cnt + 1 : 1) : 0;
                we_cnt = in_wr ? we_cnt + 1 : 1;
                in_wr  = 1;
                last_d = dq_out;
            end else if (in_wr) begin
                in_wr = 0;
                chk(we_cnt >= E_PWE && a_cnt >= E_AW && sd_cnt >= E_SD && dq_oe,
                    $sformatf("R5 write timing we=%0d addr=%0d setup=%0d hold=%0b expected >=%0d,%0d,%0d,1",
                              we_cnt, a_cnt, sd_cnt, dq_oe, E_PWE, E_AW, E_SD));
                mem_m[int'(last_a)] = (we_cnt >= E_PWE && a_cnt >= E_AW && sd_cnt >= E_SD) ? last_d : 8'hBD;
            end
            last_a = maddr;
        end
    end

    // ---------------- one host operation with per-clock pin checks ----------------
    task automatic do_op(input bit w, input logic [14:0] a, input logic [7:0] d, output logic [7:0] got);
        int len, e_ce, e_we, e_oe, e_doe, e_rdy, e_rv, e_ad;
        bit x_ce, x_we, x_oe, x_doe, x_rv;
        len = w ? E_WL : E_RL + E_HZ;
        e_ce = 0; e_we = 0; e_oe = 0; e_doe = 0; e_rdy = 0; e_rv = 0; e_ad = 0;
        got = 8'hxx;
        @(negedge clk);
        while (!rdy) @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d;
        for (int i = 1; i <= len + 1; i++) begin
            @(negedge clk);
            req = 1'b0;
            if (w) begin
                x_ce = !(i <= E_WL); x_we = !(i - 1 < E_WE); x_oe = 1'b1;
                x_doe = (i - 1 >= E_HZ) && (i - 1 <= E_WE); x_rv = 1'b0;
            end else begin
                x_ce = !(i <= E_RL); x_oe = x_ce; x_we = 1'b1;
                x_doe = 1'b0; x_rv = (i == E_CAP + 1);
            end
            if (ce_n != x_ce) e_ce++;
            if (we_n != x_we) e_we++;
            if (oe_n != x_oe) e_oe++;
            if (dq_oe != x_doe) e_doe++;
            if (rvalid != x_rv) e_rv++;
            if (rdy != (i > len)) e_rdy++;
            if (!ce_n && (maddr != a || (w && dq_oe && dq_out != d))) e_ad++;
            if (rvalid) got = rdata;
        end
        if (w) begin
            chk(e_we == 0, $sformatf("R3 R9 we_n mismatches=%0d expected 0 (WE=%0d)", e_we, E_WE));
            chk(e_oe == 0, $sformatf("R4 oe_n mismatches in write=%0d expected 0", e_oe));
            chk(e_doe == 0, $sformatf("R5 dq_oe mismatches=%0d expected 0", e_doe));
            chk(e_ce == 0, $sformatf("R3 ce_n mismatches=%0d expected 0 (WL=%0d)", e_ce, E_WL));
        end else begin
            chk(e_ce == 0 && e_oe == 0 && e_we == 0 && e_doe == 0,
                $sformatf("R6 R8 read pins ce=%0d oe=%0d we=%0d doe=%0d mismatches expected 0",
                          e_ce, e_oe, e_we, e_doe));
            chk(e_rv == 0, $sformatf("R7 rvalid mismatches=%0d expected 0 (CAP=%0d)", e_rv, E_CAP));
        end
        chk(e_rdy == 0, $sformatf("R2 rdy mismatches=%0d expected 0 (len=%0d)", e_rdy, len));
        chk(e_ad == 0, $sformatf("R3 address/data bus mismatches=%0d expected 0", e_ad));
        chk(ce_n && we_n && oe_n && !dq_oe && !rvalid,
            $sformatf("R1 standby pins ce=%0b we=%0b oe=%0b doe=%0b expected 1,1,1,0", ce_n, we_n, oe_n, dq_oe));
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] got;
        logic [14:0] a;
        repeat (4) @(negedge clk);
        chk(ce_n && we_n && oe_n && !dq_oe, $sformatf("R1 pins in reset ce=%0b we=%0b oe=%0b doe=%0b", ce_n, we_n, oe_n, dq_oe));
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdy && !rvalid && ce_n, $sformatf("R1 after reset rdy=%0b rvalid=%0b ce=%0b expected 1,0,1", rdy, rvalid, ce_n));
        chk(E_WE == 12 && E_WL == 14 && E_CAP == 14 && E_HZ == 5,
            $sformatf("R9 derived counts WE=%0d WL=%0d CAP=%0d HZ=%0d expected 12,14,14,5", E_WE, E_WL, E_CAP, E_HZ));

        // walking-one and walking-zero address sweep
        for (int b = 0; b < 15; b++) begin
            a = 15'(1 << b);
            do_op(1'b1, a, 8'(b * 17 + 3), got);
            do_op(1'b1, ~a, 8'(~(b * 17 + 3)), got);
        end
        for (int b = 0; b < 15; b++) begin
            a = 15'(1 << b);
            do_op(1'b0, a, 8'h00, got);
            chk(got == 8'(b * 17 + 3), $sformatf("R10 read addr=%h got=%h expected=%h", a, got, 8'(b * 17 + 3)));
            do_op(1'b0, ~a, 8'h00, got);
            chk(got == 8'(~(b * 17 + 3)), $sformatf("R10 read addr=%h got=%h expected=%h", ~a, got, 8'(~(b * 17 + 3))));
        end

        // every data value at one address, write then read back
        for (int v = 0; v < 256; v++) begin
            do_op(1'b1, 15'h5A5A, 8'(v), got);
            do_op(1'b0, 15'h5A5A, 8'h00, got);
            chk(got == 8'(v), $sformatf("R10 data sweep got=%h expected=%h", got, 8'(v)));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule